// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block decides which serial-port interrupt is pending and what the identification register reads back. It takes the per-source enables, the receive error and status flags, the receive queue fill level with its trigger threshold, an external character-timeout flag, the modem-line change flags, the master interrupt gate and the queue-mode indication. From these it builds a single interrupt request line and an 8-bit identification value.

Five sources are ranked in a fixed order. The highest-ranked active source selects the code in the low nibble. A master gate forces the "nothing pending" value whenever it is clear. When queue mode is on, the top two bits of the value are set. The transmit-empty source is held in a latch. Reading the identification value while that source is the one reported clears the latch, and the latch is armed again only when the holding register next goes from occupied to empty. The request line is registered and follows the identification value one clock later.

Top module: `uart_irq_prio`

## Requirements
- R1: While `out2_en` is 0, `iir_val` is 8'h01 regardless of every other input, and `irq` is 0 on the clock after any cycle with `out2_en` at 0.
- R2: Receive line status has the highest rank. It is active when `ien[2]` is 1 and any bit of `lsr_err` is 1, and it yields code 4'h6 in `iir_val[3:0]`.
- R3: Received data available ranks second. It is active when `ien[0]`, `data_ready` and (`rx_level` >= `rx_trig`) are all true, and it yields code 4'h4.
- R4: Character timeout ranks third. It is active when `ien[0]`, `data_ready` and `char_tmo` are all 1, and it yields code 4'hC. When the count has reached the trigger level, the data-available source is reported instead.
- R5: Transmit holding empty ranks fourth. It is active when `ien[1]` is 1, `thr_empty` is 1 and the transmit-empty latch is set, and it yields code 4'h2.
- R6: Modem status ranks lowest. It is active when `ien[3]` is 1 and `msr_delta` is nonzero, and it yields code 4'h0.
- R7: With `out2_en` at 1 and no active source, `iir_val[3:0]` is 4'h1. `iir_val[5:4]` is always 0.
- R8: With `out2_en` at 1, `iir_val[7:6]` is 2'b11 when `fifo_on` is 1 and 2'b00 otherwise.
- R9: `irq` is registered. After each clock edge it equals the inverse of the `iir_val[0]` value present before that edge.
- R10: The transmit-empty latch sets on the clock after `thr_empty` goes from 0 to 1, and it is cleared whenever `thr_empty` is 0. An `iir_rd` pulse in a cycle where `iir_val[3:0]` is 4'h2 clears it, and it stays clear until the next 0-to-1 change of `thr_empty`.
- R11: After reset, `irq` is 0 and the transmit-empty latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien | input | 4 | Source enables: 0 rx data/timeout, 1 tx empty, 2 line status, 3 modem |
| lsr_err | input | 4 | Receive error flags (overrun, parity, framing, break) |
| data_ready | input | 1 | Receive data present |
| thr_empty | input | 1 | Transmit holding register empty |
| rx_level | input | LVL_W | Receive queue fill count |
| rx_trig | input | LVL_W | Receive trigger threshold, in characters |
| char_tmo | input | 1 | Character timeout flag from the external timer |
| msr_delta | input | 4 | Modem line change flags |
| out2_en | input | 1 | Master interrupt gate |
| fifo_on | input | 1 | Queue mode indication |
| iir_rd | input | 1 | Identification register read strobe |
| irq | output | 1 | Registered interrupt request |
| iir_val | output | 8 | Identification register read value |

## Verification
Random cycles drive every source input together, so several sources are often active at once. This checks that only the highest-ranked one is reported and that the gate and queue-mode bits combine correctly with each code. Directed cases put the trigger comparison exactly at its boundary, with the count equal to the threshold and one below it, to separate the data-available code from the timeout code. One sequence turns the gate on and off to show its effect. Another sequence reads while the transmit-empty code is reported and then holds, drops and raises `thr_empty`. This shows that the acknowledge clears the latch and that the latch is armed again only by a fresh empty transition, not by `thr_empty` staying high.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC = 5;

  // source index = rank, 0 is the highest
  localparam int SRC_LINE   = 0;
  localparam int SRC_RXDATA = 1;
  localparam int SRC_TMO    = 2;
  localparam int SRC_TXMT   = 3;
  localparam int SRC_MODEM  = 4;

  typedef enum logic [3:0] {
    ID_MODEM  = 4'h0,
    ID_NONE   = 4'h1,
    ID_TXMT   = 4'h2,
    ID_RXDATA = 4'h4,
    ID_LINE   = 4'h6,
    ID_TMO    = 4'hC
  } irq_id_e;

  function automatic irq_id_e src_code(input int idx);
    case (idx)
      SRC_LINE:   src_code = ID_LINE;
      SRC_RXDATA: src_code = ID_RXDATA;
      SRC_TMO:    src_code = ID_TMO;
      SRC_TXMT:   src_code = ID_TXMT;
      default:    src_code = ID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_thre_latch.sv
module uart_irq_thre_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty_i,
  input  logic ack_i,
  output logic pend_o
);

  logic pend_q, pend_d;
  logic seen_q, seen_d;
  logic rise;

  assign rise = thr_empty_i & ~seen_q;

  always_comb begin
    seen_d = thr_empty_i;
    pend_d = pend_q;
    if (!thr_empty_i)  pend_d = 1'b0;
    else if (rise)     pend_d = 1'b1;
    else if (ack_i)    pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      seen_q <= seen_d;
    end
  end

  assign pend_o = pend_q;

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && pend_q) |=> !pend_q);

  // R10
  set_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(thr_empty_i) && !$past(seen_q)));

endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic [3:0]       ien,
  input  logic [3:0]       lsr_err,
  input  logic             data_ready,
  input  logic             thr_empty,
  input  logic             thre_pend,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             char_tmo,
  input  logic [3:0]       msr_delta,
  output logic [NSRC-1:0]  pend
);

  logic at_trig;
  assign at_trig = (rx_level >= rx_trig);

  always_comb begin
    pend             = '0;
    pend[SRC_LINE]   = ien[2] & (|lsr_err);
    pend[SRC_RXDATA] = ien[0] & data_ready & at_trig;
    pend[SRC_TMO]    = ien[0] & data_ready & char_tmo;
    pend[SRC_TXMT]   = ien[1] & thr_empty & thre_pend;
    pend[SRC_MODEM]  = ien[3] & (|msr_delta);
  end

endmodule

// File: rtl/uart_irq_enc.sv
module uart_irq_enc
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  output logic [3:0]      id,
  output logic            any
);

  logic [NSRC-1:0] grant;
  logic [NSRC:0]   blocked;

  assign blocked[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_rank
      assign grant[i]     = pend[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | pend[i];
    end
  endgenerate

  always_comb begin
    id = ID_NONE;
    for (int k = 0; k < NSRC; k++) begin
      if (grant[k]) id = src_code(k);
    end
  end

  assign any = blocked[NSRC];

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));

  // R2
  line_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend[SRC_LINE] |-> (id == ID_LINE));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ien,
  input  logic [3:0]       lsr_err,
  input  logic             data_ready,
  input  logic             thr_empty,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             char_tmo,
  input  logic [3:0]       msr_delta,
  input  logic             out2_en,
  input  logic             fifo_on,
  input  logic             iir_rd,
  output logic             irq,
  output logic [7:0]       iir_val
);

  logic [NSRC-1:0] pend;
  logic            thre_pend;
  logic [3:0]      id;
  logic            any;
  logic            ack;
  logic            irq_d;

  uart_irq_thre_latch u_thre (
    .clk        (clk),
    .rst_n      (rst_n),
    .thr_empty_i(thr_empty),
    .ack_i      (ack),
    .pend_o     (thre_pend)
  );

  uart_irq_src #(.LVL_W(LVL_W)) u_src (
    .ien       (ien),
    .lsr_err   (lsr_err),
    .data_ready(data_ready),
    .thr_empty (thr_empty),
    .thre_pend (thre_pend),
    .rx_level  (rx_level),
    .rx_trig   (rx_trig),
    .char_tmo  (char_tmo),
    .msr_delta (msr_delta),
    .pend      (pend)
  );

  uart_irq_enc u_enc (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (pend),
    .id   (id),
    .any  (any)
  );

  assign ack = iir_rd & out2_en & (id == ID_TXMT);

  always_comb begin
    if (!out2_en) iir_val = 8'h01;
    else          iir_val = {{2{fifo_on}}, 2'b00, id};
  end

  assign irq_d = out2_en & any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  // R1
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out2_en |=> !irq);

  // R9
  irq_follows_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == !$past(iir_val[0])));

  // R7
  mid_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iir_val[5:4] == 2'b00);

endmodule

// File: tb/uart_irq_prio_test.sv
module uart_irq_prio_test;

  localparam int LVL_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [3:0]       ien, lsr_err, msr_delta;
  logic             data_ready, thr_empty, char_tmo, out2_en, fifo_on, iir_rd;
  logic [LVL_W-1:0] rx_level, rx_trig;
  logic             irq;
  logic [7:0]       iir_val;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  // bench model state
  bit  m_pend, m_seen, m_irq;

  always #2 clk = ~clk;

  uart_irq_prio uut (
    .clk(clk), .rst_n(rst_n), .ien(ien), .lsr_err(lsr_err),
    .data_ready(data_ready), .thr_empty(thr_empty), .rx_level(rx_level),
    .rx_trig(rx_trig), .char_tmo(char_tmo), .msr_delta(msr_delta),
    .out2_en(out2_en), .fifo_on(fifo_on), .iir_rd(iir_rd),
    .irq(irq), .iir_val(iir_val)
  );

  function automatic logic [3:0] exp_code();
    if (ien[2] && lsr_err != 0)                          return 4'h6;
    if (ien[0] && data_ready && rx_level >= rx_trig)     return 4'h4;
    if (ien[0] && data_ready && char_tmo)                return 4'hC;
    if (ien[1] && thr_empty && m_pend)                   return 4'h2;
    if (ien[3] && msr_delta != 0)                        return 4'h0;
    return 4'h1;
  endfunction

  function automatic logic [7:0] exp_iir();
    if (!out2_en) return 8'h01;
    return {{2{fifo_on}}, 2'b00, exp_code()};
  endfunction

  function automatic string req_of(input logic [7:0] v);
    if (!out2_en) return "R1";
    case (v[3:0])
      4'h6: return "R2";
      4'h4: return "R3";
      4'hC: return "R4";
      4'h2: return "R5";
      4'h0: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    ien = 0; lsr_err = 0; msr_delta = 0; data_ready = 0; thr_empty = 0;
    char_tmo = 0; out2_en = 0; fifo_on = 0; iir_rd = 0; rx_level = 0; rx_trig = 0;
  endtask

  // inputs already set; check outputs, then advance model past the next edge
  task automatic step(input string tag);
    logic [7:0] e;
    #1;
    e = exp_iir();
    check((tag == "") ? req_of(e) : tag, iir_val, e);
    check("R9", {7'b0, irq}, {7'b0, m_irq});
    if (iir_val[7:6] != 2'b00 || e[7:6] != 2'b00) check("R8", {6'b0, iir_val[7:6]}, {6'b0, e[7:6]});
    // model of the latch
    if (!thr_empty)                               m_pend = 0;
    else if (!m_seen)                             m_pend = 1;
    else if (iir_rd && out2_en && e[3:0] == 4'h2) m_pend = 0;
    m_seen = thr_empty;
    m_irq  = !e[0];
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_inputs();
    rst_n = 0;
    m_pend = 0; m_seen = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {7'b0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R11", {7'b0, irq}, 8'h00);

    // R1 gate off with every source active
    ien = 4'hF; lsr_err = 4'h1; msr_delta = 4'h2; data_ready = 1; fifo_on = 1;
    rx_level = 5; rx_trig = 4; char_tmo = 1;
    step("R1"); step("R1");
    out2_en = 1; step("R2"); step("R2");

    // R3 / R4 trigger boundary
    lsr_err = 0; rx_level = 4; rx_trig = 4; step("R3");
    rx_level = 3; step("R4");
    char_tmo = 0; step("R6");
    fifo_on = 0; step("R8");

    // R10 latch sequence
    idle_inputs(); out2_en = 1; ien = 4'b0010; step("R7");
    thr_empty = 1; step("R10");        // rise seen at next edge
    step("R5");                        // code 02
    iir_rd = 1; step("R10");           // ack
    iir_rd = 0; step("R10");           // cleared, reads 01
    step("R10");                       // stays clear while high
    thr_empty = 0; step("R10");
    thr_empty = 1; step("R10");
    step("R10");                       // armed again
    ien[3] = 1; msr_delta = 4'h8; step("R5");
    iir_rd = 1; step("R10");
    iir_rd = 0; step("R6");            // modem now shown

    // random
    for (int i = 0; i < 3000; i++) begin
      ien        = $urandom_range(0, 15);
      lsr_err    = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
      msr_delta  = ($urandom_range(0, 1) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      data_ready = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) thr_empty = ~thr_empty;
      rx_level   = LVL_W'($urandom_range(0, 16));
      rx_trig    = LVL_W'($urandom_range(0, 16));
      char_tmo   = $urandom_range(0, 1);
      out2_en    = ($urandom_range(0, 5) != 0);
      fifo_on    = $urandom_range(0, 1);
      iir_rd     = ($urandom_range(0, 2) == 0);
      step("");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule